// File: doc/BRIEF.md
# Receive FIFO with Trigger Level

This block is the receive half of a register-mapped serial controller. Bytes that have already been deserialized arrive on a single-cycle valid/data strobe. They are kept in a 16-entry circular queue until software drains them through a read port. Each read of that port pops one byte.

A trigger level chosen by software sets when the block reports "enough data". Each time a byte is stored, the occupancy is compared with the level, and the comparison sets a sticky full flag. A read that drops the occupancy below the level clears the flag again. A registered interrupt output follows the flag whenever the interrupt is enabled.

The same small byte-wide register bus carries four things:
- a control register with the receive enable and interrupt enable;
- a FIFO control register with the trigger select and a flush command;
- a status register holding the data-ready, full and line-break flags;
- the data port.

A break input marks a line-break condition in the status register.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset the control and FIFO-control registers read 0x00, the status register reads 0x00, the interrupt output is low, the trigger level is 1 and a data-port read returns 0x00.
- R2: While control bit 4 (receive enable) is 1, each cycle with rx_valid high stores rx_data. Reads of the data port at offset 0x14 return the stored bytes oldest first, including when the head and tail indices wrap from 15 to 0. Status bit 0 reads 1 while the FIFO holds at least one byte.
- R3: The FIFO holds at most 16 bytes. A byte offered while 16 are held is dropped, and the held bytes are unchanged.
- R4: While control bit 4 is 0, rx_valid has no effect on the FIFO.
- R5: FIFO-control bits 7:6 select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. A stored byte that makes the occupancy equal to or greater than the level sets status bit 1 (the full flag).
- R6: A data-port pop that leaves the occupancy below the trigger level clears status bit 1. A pop that leaves it at or above the level keeps bit 1 set.
- R7: Writing the FIFO-control register (offset 0x18) with bit 1 set empties the FIFO and clears status bit 1. The other written bits are stored.
- R8: rx_irq is a registered output. It is high exactly one edge after control bit 6 (interrupt enable) and status bit 1 are both 1. Writing control with bit 6 clear therefore takes it low on the following edge.
- R9: A write to the control register (offset 0x08) stores the written value ANDed with 0xFA, so bits 0 and 2 always read back 0.
- R10: A write to the status register (offset 0x10) with bit 0 or bit 1 equal to 0 clears status bit 1, and the interrupt then falls.
- R11: A cycle with rx_break high sets status bit 4. A status write with bit 4 equal to 0 clears it. A break in the same cycle wins over the clear.
- R12: A data-port read while the FIFO is empty returns 0x00 and changes no state.
- R13: A store and a pop in the same cycle keep the occupancy unchanged, and the byte order is preserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | One received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Line-break condition seen this cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after bus_rd |
| rx_irq | output | 1 | Receive interrupt, registered level |

## Verification
The checker assumes three things about the inputs:
- bus_wr and bus_rd are never high in the same cycle;
- a FIFO-control write never lands in the same cycle as a byte arrival;
- a status write never lands in the same cycle as a byte arrival or a break pulse.

The orderings it checks are therefore only the ones named in the requirements. The bench holds to these assumptions by construction. Every bus access and every byte arrival is driven by its own task, one access per cycle with an idle cycle after it. The only overlap the bench creates on purpose is the arrival-plus-pop case of R13.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_RXD  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_FCTL = 6'h18;

  localparam logic [REG_W-1:0] CTRL_WMASK = 8'hFA;

  localparam int CTRL_RXEN  = 4;
  localparam int CTRL_RIE   = 6;
  localparam int FCTL_FLUSH = 1;
  localparam int FCTL_TSEL  = 6;
  localparam int STAT_READY = 0;
  localparam int STAT_FULL  = 1;
  localparam int STAT_BRK   = 4;

  typedef enum logic [1:0] {
    TRG_ONE      = 2'b00,
    TRG_FOUR     = 2'b01,
    TRG_EIGHT    = 2'b10,
    TRG_FOURTEEN = 2'b11
  } trig_sel_e;

  function automatic int unsigned trig_depth(input trig_sel_e sel);
    unique case (sel)
      TRG_ONE:      return 1;
      TRG_FOUR:     return 4;
      TRG_EIGHT:    return 8;
      TRG_FOURTEEN: return 14;
      default:      return 1;
    endcase
  endfunction

endpackage

// File: rtl/serial_rx_ring.sv
module serial_rx_ring #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          flush_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic [CW-1:0] cnt_nxt_o
);

  logic [PW-1:0] head_q, head_n;
  logic [PW-1:0] tail_q, tail_n;
  logic [CW-1:0] count_q, count_n;
  logic          full, empty, push_ok, pop_ok;
  logic [DW-1:0] slot [DEPTH];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (count_q == CW'(DEPTH));
    empty   = (count_q == '0);
    push_ok = push_i & ~full;
    pop_ok  = pop_i & ~empty;
    head_n  = head_q;
    tail_n  = tail_q;
    count_n = count_q;
    if (flush_i) begin
      head_n  = '0;
      tail_n  = '0;
      count_n = '0;
    end else begin
      if (push_ok) head_n = step(head_q);
      if (pop_ok)  tail_n = step(tail_q);
      unique case ({push_ok, pop_ok})
        2'b10:   count_n = count_q + 1'b1;
        2'b01:   count_n = count_q - 1'b1;
        default: count_n = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      count_q <= count_n;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic          wen;
    logic [DW-1:0] ent_q;
    assign wen = push_ok & ~flush_i & (head_q == PW'(g));
    always_ff @(posedge clk) begin
      if (wen) ent_q <= wdata_i;
    end
    assign slot[g] = ent_q;
  end

  assign rdata_o   = slot[tail_q];
  assign empty_o   = empty;
  assign push_ok_o = push_ok;
  assign pop_ok_o  = pop_ok;
  assign cnt_nxt_o = count_n;

endmodule

// File: rtl/serial_rx_trigger.sv
module serial_rx_trigger
  import serial_rx_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    lvl_sel_i,
  input  logic          push_ok_i,
  input  logic          pop_ok_i,
  input  logic          flush_i,
  input  logic          clr_i,
  input  logic          rie_i,
  input  logic [CW-1:0] cnt_nxt_i,
  output logic          rdf_o,
  output logic          irq_o
);

  logic [CW-1:0] lvl;
  logic          rdf_q, rdf_n;
  logic          irq_q, irq_n;

  assign lvl = CW'(trig_depth(trig_sel_e'(lvl_sel_i)));

  always_comb begin
    rdf_n = rdf_q;
    if (clr_i) rdf_n = 1'b0;
    if (pop_ok_i && (cnt_nxt_i < lvl)) rdf_n = 1'b0;
    if (push_ok_i && (cnt_nxt_i >= lvl)) rdf_n = 1'b1;
    if (flush_i) rdf_n = 1'b0;
    irq_n = rie_i & rdf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rdf_q <= rdf_n;
      irq_q <= irq_n;
    end
  end

  assign rdf_o = rdf_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [REG_W-1:0]  fifo_rdata,
  input  logic              fifo_empty,
  input  logic              rdf_i,
  input  logic              brk_evt_i,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              rx_en_o,
  output logic              rie_o,
  output logic [1:0]        lvl_sel_o,
  output logic              flush_o,
  output logic              clr_o,
  output logic              pop_req_o
);

  logic [REG_W-1:0] ctrl_q, ctrl_n;
  logic [REG_W-1:0] fcr_q, fcr_n;
  logic             brk_q, brk_n;
  logic [REG_W-1:0] rdata_q, rdata_n;
  logic [REG_W-1:0] stat;
  logic             wr_ctrl, wr_stat, wr_fctl;

  always_comb begin
    wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    wr_stat = bus_wr && (bus_addr == OFS_STAT);
    wr_fctl = bus_wr && (bus_addr == OFS_FCTL);

    ctrl_n = wr_ctrl ? (bus_wdata & CTRL_WMASK) : ctrl_q;
    fcr_n  = wr_fctl ? bus_wdata : fcr_q;

    brk_n = brk_q;
    if (wr_stat && !bus_wdata[STAT_BRK]) brk_n = 1'b0;
    if (brk_evt_i) brk_n = 1'b1;

    stat             = '0;
    stat[STAT_READY] = ~fifo_empty;
    stat[STAT_FULL]  = rdf_i;
    stat[STAT_BRK]   = brk_q;

    unique case (bus_addr)
      OFS_CTRL: rdata_n = ctrl_q;
      OFS_STAT: rdata_n = stat;
      OFS_RXD:  rdata_n = fifo_empty ? '0 : fifo_rdata;
      OFS_FCTL: rdata_n = fcr_q;
      default:  rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fcr_q  <= '0;
      brk_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      fcr_q  <= fcr_n;
      brk_q  <= brk_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_n;
  end

  assign bus_rdata = rdata_q;
  assign rx_en_o   = ctrl_q[CTRL_RXEN];
  assign rie_o     = ctrl_q[CTRL_RIE];
  assign lvl_sel_o = fcr_q[FCTL_TSEL +: 2];
  assign flush_o   = wr_fctl && bus_wdata[FCTL_FLUSH];
  assign clr_o     = wr_stat && (!bus_wdata[STAT_READY] || !bus_wdata[STAT_FULL]);
  assign pop_req_o = bus_rd && (bus_addr == OFS_RXD);

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [REG_W-1:0]  rx_data,
  input  logic              rx_break,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              rx_irq
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             rx_en, rie, flush, clr, pop_req, push_req;
  logic [1:0]       lvl_sel;
  logic             push_ok, pop_ok, fifo_empty, rdf;
  logic [CW-1:0]    cnt_nxt;
  logic [REG_W-1:0] fifo_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign push_req = rx_valid & rx_en;

  serial_rx_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .fifo_rdata (fifo_rdata),
    .fifo_empty (fifo_empty),
    .rdf_i      (rdf),
    .brk_evt_i  (rx_break),
    .bus_rdata  (bus_rdata),
    .rx_en_o    (rx_en),
    .rie_o      (rie),
    .lvl_sel_o  (lvl_sel),
    .flush_o    (flush),
    .clr_o      (clr),
    .pop_req_o  (pop_req)
  );

  serial_rx_ring #(
    .DEPTH (DEPTH),
    .DW    (REG_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push_i    (push_req),
    .pop_i     (pop_req),
    .flush_i   (flush),
    .wdata_i   (rx_data),
    .rdata_o   (fifo_rdata),
    .empty_o   (fifo_empty),
    .push_ok_o (push_ok),
    .pop_ok_o  (pop_ok),
    .cnt_nxt_o (cnt_nxt)
  );

  serial_rx_trigger #(
    .CW (CW)
  ) u_trig (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lvl_sel_i (lvl_sel),
    .push_ok_i (push_ok),
    .pop_ok_i  (pop_ok),
    .flush_i   (flush),
    .clr_i     (clr),
    .rie_i     (rie),
    .cnt_nxt_i (cnt_nxt),
    .rdf_o     (rdf),
    .irq_o     (rx_irq)
  );

endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_break,
  input logic          rx_en,
  input logic          rie,
  input logic          pop_req,
  input logic          flush,
  input logic          clr,
  input logic          push_ok,
  input logic          pop_ok,
  input logic [CW-1:0] count,
  input logic [CW-1:0] lvl,
  input logic          rdf,
  input logic          brk,
  input logic          rx_irq,
  input logic [7:0]    bus_rdata
);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !pop_req && !flush) |=> (count == CW'(DEPTH)));

  a_r4_rx_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (count <= $past(count)));

  a_r5_flag_at_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdf) |-> (count >= $past(lvl)));

  a_r6_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdf) |-> ((count < $past(lvl)) || $past(clr) || $past(flush)));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && !rdf));

  a_r8_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rie && rdf) |=> rx_irq);

  a_r8_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(rie && rdf) |=> !rx_irq);

  a_r11_break_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> brk);

  a_r12_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && count == '0) |=> (bus_rdata == 8'h00));

  a_r13_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok && !flush) |=> (count == $past(count)));

endmodule

bind serial_rx_fifo serial_rx_fifo_chk #(
  .DEPTH (DEPTH),
  .CW    (CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .rx_break  (rx_break),
  .rx_en     (rx_en),
  .rie       (rie),
  .pop_req   (pop_req),
  .flush     (flush),
  .clr       (clr),
  .push_ok   (push_ok),
  .pop_ok    (pop_ok),
  .count     (u_fifo.count_q),
  .lvl       (u_trig.lvl),
  .rdf       (rdf),
  .brk       (u_regs.brk_q),
  .rx_irq    (rx_irq),
  .bus_rdata (bus_rdata)
);

// File: tb/sim_serial_rx_fifo.sv
`timescale 1ns/1ps
module sim_serial_rx_fifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_break = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_irq;

  always #2.5 clk = ~clk;

  serial_rx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_irq(rx_irq)
  );

  localparam logic [5:0] A_CTRL = 6'h08, A_STAT = 6'h10, A_RXD = 6'h14, A_FCTL = 6'h18;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_tag = "";

  // scoreboard model state
  logic [7:0] exp_q[$];
  logic [7:0] m_ctrl = '0, m_fcr = '0;
  logic       m_rdf = 0, m_brk = 0, m_irq = 0;
  logic [7:0] exp_rd;
  logic       rd_seen, m_push, m_pop, m_flush;
  int         m_lvl;

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  function automatic int lvl_of(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  // monitor: predicts read data and model state at each edge, compares reads
  always @(posedge clk) begin
    if (rst_n) begin
      rd_seen = bus_rd;
      exp_rd  = 8'h00;
      if (bus_rd) begin
        case (bus_addr)
          A_CTRL: exp_rd = m_ctrl;
          A_STAT: exp_rd = {3'b000, m_brk, 2'b00, m_rdf, (exp_q.size() != 0)};
          A_RXD:  exp_rd = (exp_q.size() != 0) ? exp_q[0] : 8'h00;
          A_FCTL: exp_rd = m_fcr;
          default: exp_rd = 8'h00;
        endcase
      end
      m_irq   = m_ctrl[6] & m_rdf;
      m_lvl   = lvl_of(m_fcr[7:6]);
      m_flush = bus_wr && bus_addr == A_FCTL && bus_wdata[1];
      m_pop   = bus_rd && bus_addr == A_RXD && exp_q.size() > 0;
      m_push  = rx_valid && m_ctrl[4] && exp_q.size() < 16;
      if (bus_wr && bus_addr == A_STAT && (!bus_wdata[0] || !bus_wdata[1])) m_rdf = 0;
      if (bus_wr && bus_addr == A_STAT && !bus_wdata[4]) m_brk = 0;
      if (rx_break) m_brk = 1;
      if (m_flush) begin
        exp_q.delete();
        m_rdf = 0;
      end else begin
        if (m_pop) void'(exp_q.pop_front());
        if (m_push) exp_q.push_back(rx_data);
        if (m_pop && exp_q.size() < m_lvl) m_rdf = 0;
        if (m_push && exp_q.size() >= m_lvl) m_rdf = 1;
      end
      if (bus_wr && bus_addr == A_CTRL) m_ctrl = bus_wdata & 8'hFA;
      if (bus_wr && bus_addr == A_FCTL) m_fcr = bus_wdata;
      if (rd_seen) begin
        #1;
        check(bus_rdata, exp_rd, cur_tag);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    @(negedge clk); cur_tag = tag; bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic push_pop(input logic [7:0] d, input string tag);
    @(negedge clk); cur_tag = tag; rx_valid = 1; rx_data = d; bus_rd = 1; bus_addr = A_RXD;
    @(negedge clk); rx_valid = 0; bus_rd = 0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    check({7'b0, rx_irq}, {7'b0, exp}, tag);
    check({7'b0, m_irq}, {7'b0, exp}, {tag, " (model)"});
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got=timeout exp=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check({7'b0, rx_irq}, 8'h00, "R1 irq after reset");
    rd(A_CTRL, "R1 ctrl reset");
    rd(A_STAT, "R1 status reset");
    rd(A_FCTL, "R1 fifo ctrl reset");
    rd(A_RXD,  "R12 empty read after reset");
    rd(A_STAT, "R12 status unchanged by empty read");

    // R2 basic order, level 1
    wr(A_CTRL, 8'h10);
    push(8'h11); push(8'h22); push(8'h33);
    rd(A_STAT, "R5 status full flag at level 1");
    rd(A_RXD, "R2 first byte");
    rd(A_RXD, "R2 second byte");
    rd(A_RXD, "R2 third byte");
    rd(A_STAT, "R6 flag cleared when empty");

    // R4 receive disabled
    wr(A_CTRL, 8'h00);
    push(8'h44); push(8'h55);
    rd(A_STAT, "R4 no data stored while disabled");
    rd(A_RXD, "R4 disabled read returns zero");

    // R9 masked control write
    wr(A_CTRL, 8'hFF);
    rd(A_CTRL, "R9 control mask");

    // R5/R8/R6 level 4
    wr(A_CTRL, 8'h50);
    wr(A_FCTL, 8'h40);
    rd(A_FCTL, "R7 fifo ctrl stored");
    push(8'h01); push(8'h02); push(8'h03);
    rd(A_STAT, "R5 below level 4");
    chk_irq(1'b0, "R8 irq low below level");
    push(8'h04);
    rd(A_STAT, "R5 reaches level 4");
    chk_irq(1'b1, "R8 irq high at level");
    rd(A_RXD, "R6 pop below level");
    rd(A_STAT, "R6 flag cleared below level");
    chk_irq(1'b0, "R8 irq follows flag");
    push(8'h05);
    chk_irq(1'b1, "R8 irq high again");
    wr(A_CTRL, 8'h10);
    chk_irq(1'b0, "R8 enable cleared forces irq low");

    // R7 flush
    wr(A_FCTL, 8'h42);
    rd(A_STAT, "R7 flush clears status");
    rd(A_RXD, "R7 flushed fifo reads zero");

    // R3 and level 14, with pointer wrap
    wr(A_FCTL, 8'hC0);
    for (int i = 0; i < 13; i++) push(8'hA0 + 8'(i));
    rd(A_STAT, "R5 13 below level 14");
    push(8'hAD);
    rd(A_STAT, "R5 reaches level 14");
    for (int i = 14; i < 20; i++) push(8'hA0 + 8'(i));
    for (int i = 0; i < 16; i++) rd(A_RXD, "R3 full fifo order and drop");
    rd(A_RXD, "R3 nothing beyond 16 entries");
    rd(A_STAT, "R3 empty after drain");

    // level 8
    wr(A_FCTL, 8'h80);
    for (int i = 0; i < 8; i++) push(8'h60 + 8'(i));
    rd(A_STAT, "R5 reaches level 8");
    rd(A_RXD, "R6 pop below level 8");
    rd(A_STAT, "R6 flag cleared at 7 of 8");
    wr(A_FCTL, 8'h02);

    // R10 status write clears flag
    wr(A_CTRL, 8'h50);
    push(8'h77);
    chk_irq(1'b1, "R10 irq before clear");
    wr(A_STAT, 8'h02);
    rd(A_STAT, "R10 status bit0 clear write drops flag");
    chk_irq(1'b0, "R10 irq after clear");
    push(8'h78);
    wr(A_STAT, 8'h01);
    rd(A_STAT, "R10 status bit1 clear write drops flag");
    wr(A_FCTL, 8'h02);

    // R11 break
    @(negedge clk); rx_break = 1;
    @(negedge clk); rx_break = 0;
    rd(A_STAT, "R11 break sets bit 4");
    wr(A_STAT, 8'h03);
    rd(A_STAT, "R11 break cleared by write");

    // R13 simultaneous push and pop
    wr(A_CTRL, 8'h10);
    push(8'hC1); push(8'hC2);
    push_pop(8'hC3, "R13 pop during push");
    rd(A_RXD, "R13 second byte");
    rd(A_RXD, "R13 byte stored during pop");
    rd(A_RXD, "R13 empty after drain");

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule